// File: doc/BRIEF.md
# Link Power State Controller

This block is the device-side owner of the link's operating and power state. The block comes out of hardware reset in the RESET state and waits for the device's internal initialisation to finish, which moves it to READY. From READY the host starts normal operation by writing a state request. Once the block is running, it drops by itself into a lighter idle state and then into a deeper sleep state when the physical link stays quiet for a programmable number of cycles. The host can force a suspend at any time while the block is operating, and it brings the block back to running with a new request.

The current state is shown as a 3-bit code for a status register. An access gate tells the register front end to refuse host accesses while the block is in RESET. A low-power enable drives the power logic, and a one-cycle event carries each new state to the event ring writer. A host request that the current state does not accept leaves the state as it is and sets a sticky error flag.

States are named RESET, READY, ACTIVE (normal running), LINGER (autonomous idle), SLEEP (low power) and SUSPEND (host-forced stop). The transitions are named as follows:
- init: RESET to READY.
- start: READY to ACTIVE.
- idle: ACTIVE to LINGER.
- wake: LINGER to ACTIVE on activity.
- doze: LINGER to SLEEP.
- resume: LINGER, SLEEP or SUSPEND to ACTIVE by request.
- suspend: ACTIVE, LINGER or SLEEP to SUSPEND.

Top module: `link_pm_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, the outputs read as follows: `state_o` is 0, `host_gate` is 1, and `evt_valid`, `err_sticky` and `lp_en` are all 0.
- R2: `state_o` uses these codes: RESET=0, READY=1, ACTIVE=2, LINGER=3, SLEEP=4, SUSPEND=5. RESET moves to READY (init) on the first clock edge at which `init_done` is high.
- R3: A request is `req_valid` high together with a code on `req_code`. A request with code 2 is accepted in READY (start) and in LINGER, SLEEP or SUSPEND (resume). The state becomes ACTIVE at that edge.
- R4: A request with code 5 is accepted in ACTIVE, LINGER or SLEEP (suspend). The state becomes SUSPEND at that edge.
- R5: In ACTIVE, the state moves to LINGER (idle) at the edge that ends the N-th consecutive cycle with `link_active` low. N is `idle_limit`, and a value of 0 behaves as 1. Any cycle with `link_active` high restarts the count.
- R6: In LINGER, a cycle with `link_active` high moves the state to ACTIVE (wake). N consecutive inactive cycles, counted from entry into LINGER, move it to SLEEP (doze).
- R7: When an accepted request and a timer expiry or link activity fall in the same cycle, the request decides the next state.
- R8: Any request in READY through SUSPEND that R3 and R4 do not accept is ignored: the state does not change, and `err_sticky` is set and held until reset. Timer and activity rules still apply in that cycle. A request made in RESET is ignored without setting the error.
- R9: `evt_valid` is high for exactly the first cycle in which `state_o` shows a new value, and `evt_state` equals that new value in that cycle.
- R10: `host_gate` is high exactly while the state is RESET. `lp_en` is high exactly while the state is SLEEP or SUSPEND.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| init_done | input | 1 | Internal initialisation complete |
| req_valid | input | 1 | Host state request strobe |
| req_code | input | 3 | Requested state code |
| link_active | input | 1 | Physical link activity seen this cycle |
| idle_limit | input | IDLE_W | Inactivity timeout in cycles |
| state_o | output | 3 | Current state code |
| host_gate | output | 1 | Block host register access |
| lp_en | output | 1 | Low-power enable |
| evt_valid | output | 1 | State-change event strobe |
| evt_state | output | 3 | New state carried by the event |
| err_sticky | output | 1 | An illegal request was seen since reset |

## Verification
Two things can land in the same cycle: a host request and an autonomous move, either an inactivity expiry in ACTIVE or LINGER or a wake on activity in LINGER. Directed cases set `idle_limit` to 1 so that the expiry is certain, then issue a suspend request in that same cycle, and also make a suspend request together with activity while in LINGER. Random traffic with short limits keeps creating further collisions, including illegal requests that meet an expiry. Each cycle is judged by comparing every output with a bench model written from the requirements, in which a legal request wins and an illegal one only raises the error.

// File: rtl/link_pm_pkg.sv
package link_pm_pkg;

    localparam int STATE_W = 3;

    typedef enum logic [STATE_W-1:0] {
        PM_RESET   = 3'd0,
        PM_READY   = 3'd1,
        PM_ACTIVE  = 3'd2,
        PM_LINGER  = 3'd3,
        PM_SLEEP   = 3'd4,
        PM_SUSPEND = 3'd5
    } pm_state_e;

endpackage

// File: rtl/link_pm_req_dec.sv
module link_pm_req_dec
    import link_pm_pkg::*;
(
    input  pm_state_e              cur_state,
    input  logic                   req_valid,
    input  logic [STATE_W-1:0]     req_code,
    output logic                   accept,
    output logic                   reject
);

    logic legal;

    // Legal pairs of (current state, requested code)
    always_comb begin
        legal = 1'b0;
        unique case (cur_state)
            PM_RESET:   legal = 1'b0;
            PM_READY:   legal = (req_code == PM_ACTIVE);
            PM_ACTIVE:  legal = (req_code == PM_SUSPEND);
            PM_LINGER:  legal = (req_code == PM_ACTIVE) || (req_code == PM_SUSPEND);
            PM_SLEEP:   legal = (req_code == PM_ACTIVE) || (req_code == PM_SUSPEND);
            PM_SUSPEND: legal = (req_code == PM_ACTIVE);
            default:    legal = 1'b0;
        endcase
    end

    assign accept = req_valid && legal;
    // Requests in RESET are blocked at the gate and never flagged
    assign reject = req_valid && !legal && (cur_state != PM_RESET);

endmodule

// File: rtl/link_pm_idle_timer.sv
module link_pm_idle_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             timed,
    input  logic             link_active,
    input  logic             restart,
    input  logic [CNT_W-1:0] limit,
    output logic             expire
);

    localparam int SUM_W = CNT_W + 1;

    logic [CNT_W-1:0] cnt;
    logic [SUM_W-1:0] cnt_inc;

    assign cnt_inc = {1'b0, cnt} + {{CNT_W{1'b0}}, 1'b1};
    // cnt_inc is the number of inactive cycles including this one; limit 0 acts as 1
    assign expire  = timed && !link_active && (cnt_inc >= {1'b0, limit});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!timed || link_active || restart) begin
            cnt <= '0;
        end else begin
            cnt <= cnt_inc[CNT_W-1:0];
        end
    end

endmodule

// File: rtl/link_pm_fsm.sv
module link_pm_fsm
    import link_pm_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               init_done,
    input  logic               accept,
    input  logic [STATE_W-1:0] req_code,
    input  logic               link_active,
    input  logic               expire,
    output pm_state_e          state,
    output pm_state_e          state_nxt,
    output logic               chg,
    output logic               timed,
    output logic               gate,
    output logic               lp
);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= PM_RESET;
        end else begin
            state <= state_nxt;
        end
    end

    // Next state: an accepted request takes precedence over autonomous moves
    always_comb begin
        state_nxt = state;
        unique case (state)
            PM_RESET: begin
                if (init_done) state_nxt = PM_READY;
            end
            PM_READY: begin
                if (accept) state_nxt = pm_state_e'(req_code);
            end
            PM_ACTIVE: begin
                if (accept)      state_nxt = pm_state_e'(req_code);
                else if (expire) state_nxt = PM_LINGER;
            end
            PM_LINGER: begin
                if (accept)           state_nxt = pm_state_e'(req_code);
                else if (link_active) state_nxt = PM_ACTIVE;
                else if (expire)      state_nxt = PM_SLEEP;
            end
            PM_SLEEP, PM_SUSPEND: begin
                if (accept) state_nxt = pm_state_e'(req_code);
            end
            default: state_nxt = PM_RESET;
        endcase
    end

    assign chg = (state_nxt != state);

    // Per-state outputs
    always_comb begin
        timed = 1'b0;
        gate  = 1'b0;
        lp    = 1'b0;
        unique case (state)
            PM_RESET:             gate  = 1'b1;
            PM_READY:             ;
            PM_ACTIVE, PM_LINGER: timed = 1'b1;
            PM_SLEEP, PM_SUSPEND: lp    = 1'b1;
            default:              gate  = 1'b1;
        endcase
    end

endmodule

// File: rtl/link_pm_evt.sv
module link_pm_evt
    import link_pm_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               chg,
    input  pm_state_e          state_nxt,
    input  logic               reject,
    output logic               evt_valid,
    output logic [STATE_W-1:0] evt_state,
    output logic               err_sticky
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            evt_valid  <= 1'b0;
            evt_state  <= '0;
            err_sticky <= 1'b0;
        end else begin
            evt_valid <= chg;
            if (chg) evt_state <= state_nxt;
            if (reject) err_sticky <= 1'b1;
        end
    end

endmodule

// File: rtl/link_pm_ctrl.sv
module link_pm_ctrl
    import link_pm_pkg::*;
#(
    parameter int IDLE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_done,
    input  logic              req_valid,
    input  logic [2:0]        req_code,
    input  logic              link_active,
    input  logic [IDLE_W-1:0] idle_limit,
    output logic [2:0]        state_o,
    output logic              host_gate,
    output logic              lp_en,
    output logic              evt_valid,
    output logic [2:0]        evt_state,
    output logic              err_sticky
);

    pm_state_e state;
    pm_state_e state_nxt;
    logic      chg;
    logic      timed;
    logic      accept;
    logic      reject;
    logic      expire;

    link_pm_req_dec u_dec (
        .cur_state (state),
        .req_valid (req_valid),
        .req_code  (req_code),
        .accept    (accept),
        .reject    (reject)
    );

    link_pm_idle_timer #(.CNT_W(IDLE_W)) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .timed       (timed),
        .link_active (link_active),
        .restart     (chg),
        .limit       (idle_limit),
        .expire      (expire)
    );

    link_pm_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .init_done   (init_done),
        .accept      (accept),
        .req_code    (req_code),
        .link_active (link_active),
        .expire      (expire),
        .state       (state),
        .state_nxt   (state_nxt),
        .chg         (chg),
        .timed       (timed),
        .gate        (host_gate),
        .lp          (lp_en)
    );

    link_pm_evt u_evt (
        .clk        (clk),
        .rst_n      (rst_n),
        .chg        (chg),
        .state_nxt  (state_nxt),
        .reject     (reject),
        .evt_valid  (evt_valid),
        .evt_state  (evt_state),
        .err_sticky (err_sticky)
    );

    assign state_o = state;

endmodule

// File: rtl/link_pm_chk.sv
module link_pm_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] state_o,
    input logic       evt_valid,
    input logic [2:0] evt_state,
    input logic       err_sticky,
    input logic       host_gate,
    input logic       lp_en
);

    // R2: RESET only goes on to READY
    assert_reset_exit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_o) == 3'd0) |-> (state_o == 3'd0 || state_o == 3'd1));

    // R4: SUSPEND is entered only from ACTIVE, LINGER or SLEEP
    assert_suspend_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd5 && $past(state_o) != 3'd5) |->
        ($past(state_o) == 3'd2 || $past(state_o) == 3'd3 || $past(state_o) == 3'd4));

    // R6: SLEEP is entered only from LINGER
    assert_sleep_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd4 && $past(state_o) != 3'd4) |-> ($past(state_o) == 3'd3));

    // R8: error flag is sticky
    assert_err_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err_sticky |=> err_sticky);

    // R9: every state change is announced with the new code
    assert_evt_on_change_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o != $past(state_o)) |-> (evt_valid && evt_state == state_o));

    // R9: no event without a state change
    assert_evt_only_change_R9: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |-> (state_o != $past(state_o)));

    // R10: gate and low-power enable never both active
    assert_gate_lp_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_gate && lp_en));

endmodule

bind link_pm_ctrl link_pm_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .state_o    (state_o),
    .evt_valid  (evt_valid),
    .evt_state  (evt_state),
    .err_sticky (err_sticky),
    .host_gate  (host_gate),
    .lp_en      (lp_en)
);

// File: tb/link_pm_ctrl_tb.sv
`timescale 1ns/1ps
module link_pm_ctrl_tb;

    localparam int IDLE_W = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              init_done = 1'b0;
    logic              req_valid = 1'b0;
    logic [2:0]        req_code = '0;
    logic              link_active = 1'b0;
    logic [IDLE_W-1:0] idle_limit = 16'd3;
    logic [2:0]        state_o;
    logic              host_gate;
    logic              lp_en;
    logic              evt_valid;
    logic [2:0]        evt_state;
    logic              err_sticky;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // reference model state
    logic [2:0]        m_st;
    logic [IDLE_W:0]   m_cnt;
    logic              m_err;
    logic              m_evt;
    string             m_tag;

    always #2 clk = ~clk;

    link_pm_ctrl #(.IDLE_W(IDLE_W)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .init_done   (init_done),
        .req_valid   (req_valid),
        .req_code    (req_code),
        .link_active (link_active),
        .idle_limit  (idle_limit),
        .state_o     (state_o),
        .host_gate   (host_gate),
        .lp_en       (lp_en),
        .evt_valid   (evt_valid),
        .evt_state   (evt_state),
        .err_sticky  (err_sticky)
    );

    function automatic bit legal_req(input logic [2:0] st, input logic [2:0] code);
        if (st == 3'd1) return code == 3'd2;
        if (st == 3'd2) return code == 3'd5;
        if (st == 3'd3 || st == 3'd4) return code == 3'd2 || code == 3'd5;
        if (st == 3'd5) return code == 3'd2;
        return 1'b0;
    endfunction

    task automatic check(input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic model_step();
        logic [2:0] ns;
        bit timed, exp_t, acc;
        ns    = m_st;
        timed = (m_st == 3'd2 || m_st == 3'd3);
        exp_t = timed && !link_active && ((m_cnt + 1) >= {1'b0, idle_limit});
        acc   = req_valid && legal_req(m_st, req_code);
        m_tag = "R5";
        if (m_st == 3'd0) begin
            m_tag = "R2";
            if (init_done) ns = 3'd1;
        end else if (acc) begin
            ns = req_code;
            m_tag = (req_code == 3'd5) ? "R4" : "R3";
        end else begin
            if (req_valid) begin
                m_err = 1'b1;
                m_tag = "R8";
            end
            if (m_st == 3'd3 && link_active) begin
                ns = 3'd2; m_tag = "R6";
            end else if (exp_t) begin
                ns = (m_st == 3'd2) ? 3'd3 : 3'd4;
                m_tag = (m_st == 3'd2) ? "R5" : "R6";
            end
        end
        m_cnt = (!timed || link_active || ns != m_st) ? '0 : m_cnt + 1;
        m_evt = (ns != m_st);
        m_st  = ns;
    endtask

    task automatic compare(input string tag);
        check(tag, state_o, m_st);
        check("R9", evt_valid, m_evt);
        if (m_evt) check("R9", evt_state, m_st);
        check("R8", err_sticky, m_err);
        check("R10", host_gate, m_st == 3'd0);
        check("R10", lp_en, (m_st == 3'd4 || m_st == 3'd5));
    endtask

    // Drive one cycle of inputs, advance the model and the design, compare.
    task automatic cyc(input bit rv, input logic [2:0] rc, input bit act,
                       input bit ini, input string tag);
        req_valid   = rv;
        req_code    = rc;
        link_active = act;
        init_done   = ini;
        model_step();
        @(posedge clk);
        #1;
        compare(tag == "" ? m_tag : tag);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        req_valid = 1'b0; init_done = 1'b0; link_active = 1'b0;
        m_st = 3'd0; m_cnt = '0; m_err = 1'b0; m_evt = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        compare("R1");
        rst_n = 1'b1;
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        #1;
        do_reset();
        // R1: first cycle after release, nothing has moved yet
        cyc(1'b0, 3'd0, 1'b0, 1'b0, "R1");
        // R8: request while in RESET is ignored without error
        cyc(1'b1, 3'd2, 1'b0, 1'b0, "R8");
        check("R8", err_sticky, 0);
        // R2: init
        cyc(1'b0, 3'd0, 1'b0, 1'b1, "R2");
        check("R2", state_o, 1);
        // R3: start
        cyc(1'b1, 3'd2, 1'b1, 1'b0, "R3");
        check("R3", state_o, 2);
        // R5: activity restarts the count, then three quiet cycles
        idle_limit = 16'd3;
        cyc(1'b0, 3'd0, 1'b0, 1'b0, "R5");
        cyc(1'b0, 3'd0, 1'b0, 1'b0, "R5");
        cyc(1'b0, 3'd0, 1'b1, 1'b0, "R5");
        cyc(1'b0, 3'd0, 1'b0, 1'b0, "R5");
        cyc(1'b0, 3'd0, 1'b0, 1'b0, "R5");
        check("R5", state_o, 2);
        cyc(1'b0, 3'd0, 1'b0, 1'b0, "R5");
        check("R5", state_o, 3);
        // R6: wake, then idle again and doze
        cyc(1'b0, 3'd0, 1'b1, 1'b0, "R6");
        check("R6", state_o, 2);
        for (int i = 0; i < 6; i++) cyc(1'b0, 3'd0, 1'b0, 1'b0, "R6");
        check("R6", state_o, 4);
        check("R10", lp_en, 1);
        // R4: suspend from SLEEP, R3: resume
        cyc(1'b1, 3'd5, 1'b0, 1'b0, "R4");
        check("R4", state_o, 5);
        cyc(1'b1, 3'd2, 1'b0, 1'b0, "R3");
        check("R3", state_o, 2);
        // R7: expiry and suspend request in the same cycle
        idle_limit = 16'd1;
        cyc(1'b1, 3'd5, 1'b0, 1'b0, "R7");
        check("R7", state_o, 5);
        cyc(1'b1, 3'd2, 1'b0, 1'b0, "R3");
        cyc(1'b0, 3'd0, 1'b0, 1'b0, "R5");
        check("R5", state_o, 3);
        // R7: activity and suspend request together in LINGER
        cyc(1'b1, 3'd5, 1'b1, 1'b0, "R7");
        check("R7", state_o, 5);
        // R8: illegal request in SUSPEND leaves the state and sets the error
        cyc(1'b1, 3'd4, 1'b0, 1'b0, "R8");
        check("R8", state_o, 5);
        check("R8", err_sticky, 1);
        cyc(1'b0, 3'd0, 1'b0, 1'b0, "R8");
        check("R8", err_sticky, 1);
        // limit 0 behaves as 1
        cyc(1'b1, 3'd2, 1'b0, 1'b0, "R3");
        idle_limit = 16'd0;
        cyc(1'b0, 3'd0, 1'b0, 1'b0, "R5");
        check("R5", state_o, 3);

        // Constrained random traffic, with one reset midway
        for (int n = 0; n < 4000; n++) begin
            bit rv, act, ini;
            logic [2:0] rc;
            if (n == 2000) do_reset();
            if (($urandom % 50) == 0) idle_limit = IDLE_W'($urandom % 6);
            rv  = (($urandom % 8) == 0);
            rc  = ($urandom % 4 == 0) ? 3'($urandom) : (($urandom % 2) ? 3'd2 : 3'd5);
            act = (($urandom % 5) == 0);
            ini = (($urandom % 4) == 0);
            cyc(rv, rc, act, ini, "");
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule